// File: doc/BRIEF.md
# Bootstrap SRAM Copy Engine

The block holds a small bootstrap memory that keeps its contents through power-save sleep. A host fills this memory one dword at a time over a simple register bus. When commanded, the block copies a programmed run of dwords out of that memory into a processor instruction memory. The copy goes out through a dedicated valid/ready write port that moves one dword per accepted handshake.

A copy begins in one of two ways. The host can write a start bit, which then reads back as 1 until the last dword has been accepted, so the host can poll it. Alternatively, while an arm bit is set, every power-up event launches the same copy again with whatever source, destination and count are currently programmed.

On the write port, the block raises `im_valid` together with an address and data word. It keeps all three unchanged until it samples `im_ready` high on a rising clock edge. A transfer happens on each edge where both `im_valid` and `im_ready` are high. The consumer may hold `im_ready` low for any number of cycles.

Top module: `boot_copy_engine`

## Requirements
- R1: After synchronous reset, every register (control, source, destination, count, status) reads 0 and `im_valid` is low.
- R2: Register map, as byte offsets on `bus_addr`:
  - 0x000 is control, with bit 31 = start/busy and bit 30 = arm.
  - 0x004 is the source dword index, bits [7:0].
  - 0x008 is the destination dword address, bits [15:0].
  - 0x00C is the dword count, bits [8:0].
  - 0x010 is status, with bit 0 = done.
  - The programmable fields read back what was written.
- R3: The bootstrap memory is 256 dwords. It is read and written at byte offset 0x400 + 4*index, and reads return the last dword written there.
- R4: Writing control with bit 31 = 1 while idle starts a copy. Bit 31 reads 1 from the next cycle until the cycle after the last handshake, when it reads 0 and status bit 0 reads 1.
- R5: The copy makes exactly count handshakes. Handshake k carries address (destination + k) mod 2^16 and data from memory index (source + k) mod 256.
- R6: While `im_valid` is high and `im_ready` is low, `im_valid`, `im_addr` and `im_data` hold steady on the next cycle.
- R7: A start with count 0 never raises `im_valid`. Bit 31 reads 0 and done reads 1 on the next cycle.
- R8: With the arm bit set and the block idle, a one-cycle `pwr_up` pulse starts the programmed copy. With the arm bit clear, `pwr_up` has no effect.
- R9: While a copy runs, the following are ignored: a start write, a `pwr_up` pulse, and a write to the memory window. The arm bit itself still updates.
- R10: Status done reads 0 from the cycle after a non-zero copy begins until that copy ends.
- R11: Synchronous reset clears registers and status but leaves the bootstrap memory contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | 11 | Register bus byte address |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data, combinational from `bus_addr` |
| pwr_up | input | 1 | Power-up event pulse |
| im_valid | output | 1 | Instruction memory write request |
| im_ready | input | 1 | Instruction memory accepts the request |
| im_addr | output | 16 | Instruction memory dword address |
| im_data | output | 32 | Instruction memory write data |

## Verification
The copy is exercised under three consumer patterns:
- **Ready held high** shows the one-dword-per-cycle rate and the exact cycle the start bit drops.
- **Pseudo-random ready** separates a port that holds its word under stall from one that skips or repeats words.
- **Ready held low** keeps a copy open long enough to fire start writes, power-up pulses and memory writes into it.

Source and destination values close to the top of their ranges show whether the pointers wrap correctly. A zero count and a disarmed power-up pulse show whether the block starts when it must not. Reading back a memory word after a reset tells a cleared memory apart from a retained one.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;

  // Register selection decoded from the bus address.
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_SRC,
    SEL_DST,
    SEL_CNT,
    SEL_STAT,
    SEL_MEM
  } reg_sel_e;

  localparam int unsigned OFS_CTRL  = 32'h000;
  localparam int unsigned OFS_SRC   = 32'h004;
  localparam int unsigned OFS_DST   = 32'h008;
  localparam int unsigned OFS_CNT   = 32'h00C;
  localparam int unsigned OFS_STAT  = 32'h010;

  localparam int START_BIT = 31;
  localparam int ARM_BIT   = 30;

  function automatic reg_sel_e decode_sel(input logic in_window, input int unsigned ofs);
    if (in_window) return SEL_MEM;
    case (ofs)
      OFS_CTRL: return SEL_CTRL;
      OFS_SRC:  return SEL_SRC;
      OFS_DST:  return SEL_DST;
      OFS_CNT:  return SEL_CNT;
      OFS_STAT: return SEL_STAT;
      default:  return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/boot_sram.sv
module boot_sram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    ra_addr,
  output logic [WIDTH-1:0] ra_data,
  input  logic [AW-1:0]    rb_addr,
  output logic [WIDTH-1:0] rb_data
);
  // No reset: contents survive everything except an explicit rewrite.
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign ra_data = cells[ra_addr];
  assign rb_data = cells[rb_addr];
endmodule

// File: rtl/boot_copy_seq.sv
module boot_copy_seq #(
  parameter int SRC_W = 8,
  parameter int DST_W = 16,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [SRC_W-1:0] job_src,
  input  logic [DST_W-1:0] job_dst,
  input  logic [CNT_W-1:0] job_cnt,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [DST_W-1:0] out_addr,
  output logic [SRC_W-1:0] src_ptr,
  output logic             busy,
  output logic             done
);
  logic             busy_q, done_q;
  logic [SRC_W-1:0] src_q;
  logic [DST_W-1:0] dst_q;
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      src_q    <= '0;
      dst_q    <= '0;
      remain_q <= '0;
    end else if (!busy_q) begin
      if (launch) begin
        // A zero-length job finishes on the spot.
        busy_q   <= (job_cnt != '0);
        done_q   <= (job_cnt == '0);
        src_q    <= job_src;
        dst_q    <= job_dst;
        remain_q <= job_cnt;
      end
    end else if (out_ready) begin
      src_q    <= src_q + SRC_W'(1);
      dst_q    <= dst_q + DST_W'(1);
      remain_q <= remain_q - CNT_W'(1);
      if (remain_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign out_valid = busy_q;
  assign out_addr  = dst_q;
  assign src_ptr   = src_q;
  assign busy      = busy_q;
  assign done      = done_q;
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine
  import boot_copy_pkg::*;
#(
  parameter int MEM_DW = 256,
  parameter int DST_W  = 16,
  localparam int MEM_AW = $clog2(MEM_DW),
  localparam int BUS_AW = MEM_AW + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              pwr_up,
  output logic              im_valid,
  input  logic              im_ready,
  output logic [DST_W-1:0]  im_addr,
  output logic [31:0]       im_data
);
  localparam int CNT_W = MEM_AW + 1;

  reg_sel_e          sel;
  logic              arm_q;
  logic [MEM_AW-1:0] src_q, src_ptr;
  logic [DST_W-1:0]  dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy, done, launch, mem_we;
  logic [31:0]       mem_rd;

  assign sel = decode_sel(bus_addr[BUS_AW-1], int'(bus_addr[BUS_AW-2:0]));

  // Either trigger starts a job only when idle.
  assign launch = !busy &&
                  ((bus_wr && sel == SEL_CTRL && bus_wdata[START_BIT]) ||
                   (pwr_up && arm_q));

  // Memory writes are refused while a copy reads from it.
  assign mem_we = bus_wr && sel == SEL_MEM && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_CTRL: arm_q <= bus_wdata[ARM_BIT];
        SEL_SRC:  src_q <= bus_wdata[MEM_AW-1:0];
        SEL_DST:  dst_q <= bus_wdata[DST_W-1:0];
        SEL_CNT:  cnt_q <= bus_wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  boot_sram #(.DEPTH(MEM_DW), .WIDTH(32)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (bus_addr[MEM_AW+1:2]),
    .wdata   (bus_wdata),
    .ra_addr (bus_addr[MEM_AW+1:2]),
    .ra_data (mem_rd),
    .rb_addr (src_ptr),
    .rb_data (im_data)
  );

  boot_copy_seq #(.SRC_W(MEM_AW), .DST_W(DST_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .job_src   (src_q),
    .job_dst   (dst_q),
    .job_cnt   (cnt_q),
    .out_ready (im_ready),
    .out_valid (im_valid),
    .out_addr  (im_addr),
    .src_ptr   (src_ptr),
    .busy      (busy),
    .done      (done)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_CTRL: begin
        bus_rdata[START_BIT] = busy;
        bus_rdata[ARM_BIT]   = arm_q;
      end
      SEL_SRC:  bus_rdata = 32'(src_q);
      SEL_DST:  bus_rdata = 32'(dst_q);
      SEL_CNT:  bus_rdata = 32'(cnt_q);
      SEL_STAT: bus_rdata = {31'b0, done};
      SEL_MEM:  bus_rdata = mem_rd;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/boot_copy_chk.sv
module boot_copy_chk #(
  parameter int DST_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             im_valid,
  input logic             im_ready,
  input logic [DST_W-1:0] im_addr,
  input logic [31:0]      im_data,
  input logic             busy,
  input logic             done
);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (im_valid && !im_ready) |=> (im_valid && $stable(im_addr) && $stable(im_data)));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((im_valid && im_ready) ##1 im_valid) |-> (im_addr == DST_W'($past(im_addr) + 1'b1)));

  // R4
  finish_done_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> done);

  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !done);

  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
endmodule

bind boot_copy_engine boot_copy_chk #(.DST_W(DST_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .im_valid (im_valid),
  .im_ready (im_ready),
  .im_addr  (im_addr),
  .im_data  (im_data),
  .busy     (busy),
  .done     (done)
);

// File: tb/sim_boot_copy_engine.sv
module sim_boot_copy_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwr_up = 1'b0;
  logic        im_valid;
  logic        im_ready = 1'b1;
  logic [15:0] im_addr;
  logic [31:0] im_data;

  always #5 clk = ~clk;

  boot_copy_engine u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_up(pwr_up),
    .im_valid(im_valid), .im_ready(im_ready), .im_addr(im_addr), .im_data(im_data)
  );

  int n_chk = 0, n_bad = 0, hs = 0, mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // ---------------- reference model ----------------
  typedef struct { int a; logic [31:0] d; } xfer_t;
  xfer_t       q[$];
  logic [31:0] m_mem [256];
  bit          m_arm, m_done;
  int          m_src, m_dst, m_cnt;

  function automatic logic [31:0] pat(int i);
    return {8'hB0, 8'(i), 16'(i * 37 + 5)};
  endfunction

  always @(posedge clk) begin
    bit was_busy, go, o_arm;
    int o_src, o_dst, o_cnt;
    if (rst) begin
      m_arm = 0; m_done = 0; m_src = 0; m_dst = 0; m_cnt = 0;
      q.delete();
    end else begin
      was_busy = (q.size() > 0);
      go = 0;
      o_arm = m_arm; o_src = m_src; o_dst = m_dst; o_cnt = m_cnt;
      if (was_busy && im_ready) begin
        void'(q.pop_front());
        if (q.size() == 0) m_done = 1;
      end
      if (bus_wr) begin
        if (bus_addr[10]) begin
          if (!was_busy) m_mem[bus_addr[9:2]] = bus_wdata;
        end else begin
          case (bus_addr)
            11'h000: begin
              m_arm = bus_wdata[30];
              if (bus_wdata[31] && !was_busy) go = 1;
            end
            11'h004: m_src = int'(bus_wdata[7:0]);
            11'h008: m_dst = int'(bus_wdata[15:0]);
            11'h00C: m_cnt = int'(bus_wdata[8:0]);
            default: ;
          endcase
        end
      end
      if (pwr_up && o_arm && !was_busy) go = 1;
      if (go) begin
        m_done = (o_cnt == 0);
        for (int k = 0; k < o_cnt; k++) begin
          xfer_t x;
          x.a = (o_dst + k) & 16'hFFFF;
          x.d = m_mem[(o_src + k) % 256];
          q.push_back(x);
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    im_ready <= (mode == 0) ? 1'b1 : (mode == 2) ? 1'b0 : lfsr[0];
    if (!rst) begin
      check(im_valid == (q.size() > 0), "R5/R6 write port valid", 32'(im_valid), 32'(q.size() > 0));
      if (im_valid && q.size() > 0) begin
        check(im_addr == 16'(q[0].a), "R5 write address", 32'(im_addr), 32'(q[0].a));
        check(im_data == q[0].d, "R5 write data", im_data, q[0].d);
      end
    end
  end

  always @(posedge clk) if (!rst && im_valid && im_ready) hs++;

  task automatic wr(logic [10:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [10:0] a, logic [31:0] e, string tag);
    bus_addr = a;
    #1;
    check(bus_rdata == e, tag, bus_rdata, e);
  endtask

  task automatic pulse_pwr();
    @(negedge clk); pwr_up = 1'b1;
    @(negedge clk); pwr_up = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      bus_addr = 11'h000;
      #1;
      check(bus_rdata[31] == (q.size() > 0), "R4 start bit tracks copy", 32'(bus_rdata[31]), 32'(q.size() > 0));
      if (!bus_rdata[31]) break;
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd_chk(11'h000, 32'h0, "R1 ctrl after reset");
    rd_chk(11'h004, 32'h0, "R1 src after reset");
    rd_chk(11'h008, 32'h0, "R1 dst after reset");
    rd_chk(11'h00C, 32'h0, "R1 cnt after reset");
    rd_chk(11'h010, 32'h0, "R1 status after reset");
    check(im_valid == 1'b0, "R1 im_valid after reset", 32'(im_valid), 32'h0);

    // R3 fill and read back bootstrap memory
    for (int i = 0; i < 256; i++) wr(11'(32'h400 + 4 * i), pat(i));
    rd_chk(11'h41C, pat(7), "R3 memory word 7");
    rd_chk(11'h7FC, pat(255), "R3 memory word 255");

    // R2 register readback
    wr(11'h004, 32'h0); wr(11'h008, 32'h100); wr(11'h00C, 32'd8);
    rd_chk(11'h004, 32'h0, "R2 src readback");
    rd_chk(11'h008, 32'h100, "R2 dst readback");
    rd_chk(11'h00C, 32'd8, "R2 cnt readback");

    // R4/R5 copy with ready always high
    h0 = hs;
    wr(11'h000, 32'h8000_0000);
    rd_chk(11'h000, 32'h8000_0000, "R4 start bit reads 1 during copy");
    wait_idle();
    check(hs - h0 == 8, "R5 handshake count ready-high", 32'(hs - h0), 32'd8);
    rd_chk(11'h010, 32'h1, "R4 done after copy");

    // R5/R6 wrap of source and destination under random ready
    mode = 1;
    wr(11'h004, 32'd250); wr(11'h008, 32'hFFFC); wr(11'h00C, 32'd10);
    h0 = hs;
    wr(11'h000, 32'h8000_0000);
    wait_idle();
    check(hs - h0 == 10, "R6 handshake count random ready", 32'(hs - h0), 32'd10);
    rd_chk(11'h010, 32'h1, "R5 done after wrapping copy");

    // R10 done clears when new copy starts; R9 ignored events during copy
    mode = 2;
    wr(11'h004, 32'h0); wr(11'h008, 32'h40); wr(11'h00C, 32'd20);
    h0 = hs;
    wr(11'h000, 32'h8000_0000);
    rd_chk(11'h010, 32'h0, "R10 done cleared at start");
    wr(11'h000, 32'hC000_0000);
    rd_chk(11'h000, 32'hC000_0000, "R9 arm updates while busy");
    pulse_pwr();
    wr(11'h40C, 32'hDEAD_BEEF);
    mode = 0;
    wait_idle();
    check(hs - h0 == 20, "R9 no extra copy from start or power-up", 32'(hs - h0), 32'd20);
    rd_chk(11'h40C, pat(3), "R9 memory write during copy rejected");
    rd_chk(11'h000, 32'h4000_0000, "R9 arm kept after copy");

    // R7 zero count
    wr(11'h00C, 32'd0);
    h0 = hs;
    wr(11'h000, 32'h8000_0000);
    rd_chk(11'h000, 32'h0, "R7 start bit clear at once");
    rd_chk(11'h010, 32'h1, "R7 done at once");
    repeat (3) @(negedge clk);
    check(hs == h0, "R7 no writes for zero count", 32'(hs - h0), 32'd0);

    // R8 armed and disarmed power-up
    wr(11'h004, 32'd5); wr(11'h008, 32'h200); wr(11'h00C, 32'd4);
    wr(11'h000, 32'h4000_0000);
    h0 = hs;
    mode = 1;
    pulse_pwr();
    rd_chk(11'h000, 32'hC000_0000, "R8 armed power-up started copy");
    wait_idle();
    check(hs - h0 == 4, "R8 power-up copy length", 32'(hs - h0), 32'd4);
    mode = 0;
    wr(11'h000, 32'h0);
    h0 = hs;
    pulse_pwr();
    rd_chk(11'h000, 32'h0, "R8 disarmed power-up ignored");
    repeat (3) @(negedge clk);
    check(hs == h0, "R8 no writes when disarmed", 32'(hs - h0), 32'd0);

    // R11 reset keeps memory
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd_chk(11'h004, 32'h0, "R11 src cleared");
    rd_chk(11'h00C, 32'h0, "R11 cnt cleared");
    rd_chk(11'h010, 32'h0, "R11 status cleared");
    rd_chk(11'h414, pat(5), "R11 memory retained");

    summary();
  end
endmodule